// File: doc/BRIEF.md
# Priority interrupt routing unit

This block takes the single interrupt request raised by a network controller core and sends it to one destination on the host microcontroller. The request can go to either of the host's two active-low external interrupt inputs, or to one of eight general-purpose port pins. A 3-bit field picks which port pin. Software sets the destination through one 8-bit control register. The register sits at a fixed offset in the controller's register window and is reached by a simple write/read port.

When more than one destination is enabled, a fixed priority picks the winner, so the request appears on exactly one line. The host interrupt pins are shared with other sources. Each host pin has an incoming active-low line carrying those sources, and the block merges its routed request onto it as a wired-AND. Any source that drives low therefore asserts the pin.

The register also holds a double-data-rate request bit. This bit does not affect routing. It is only exported, so that the clocking logic can act on it and a setup block can check that the slow-arbitration mode it needs is set.

Top module: `irq_steer_top`

## Requirements
- R1: After a synchronous reset every field is 0. A read at offset 0x09 returns 0x00, both host interrupt outputs follow their incoming lines, every port pin is 1, and the rate output is 0.
- R2: A write with the address at offset 0x09 stores data bits 6:0 at the next rising clock edge. A read at that offset returns the stored bits, and bit 7 always reads 0 whatever was written. Field layout: bit 0 enables host interrupt 0, bit 1 enables host interrupt 1, bit 2 enables port routing, bits 5:3 are the port pin select, and bit 6 is the double-rate request.
- R3: A write at any other offset leaves the register unchanged. A read at any other offset returns 0x00.
- R4: With the request high and bit 0 set, host interrupt 0 output is low. The request is active high.
- R5: The destinations have a fixed priority: host interrupt 0 first, then host interrupt 1, then the port pin. Only the highest-priority enabled destination is driven, and a lower-priority destination never fires while a higher one is enabled.
- R6: Each host interrupt output is the wired-AND of its incoming active-low line and the routed request. It is low whenever the incoming line is low, or whenever the block routes the request to that pin.
- R7: When port routing wins, the pin whose index equals bits 5:3 in binary is driven to 0. Value 000 selects pin 0 and value 111 selects pin 7.
- R8: Every port pin that is not selected, and every pin when port routing does not win, sits at 1.
- R9: The rate output equals stored bit 6 and has no effect on any routed output.
- R10: The routed outputs follow the request and the incoming lines combinationally, with no clock of latency. A register write changes the routing from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| core_irq | input | 1 | Interrupt request from the network core, active high |
| host_int0_n_in | input | 1 | Other sources on host interrupt 0, active low |
| host_int1_n_in | input | 1 | Other sources on host interrupt 1, active low |
| host_int0_n_out | output | 1 | Merged host interrupt 0, active low |
| host_int1_n_out | output | 1 | Merged host interrupt 1, active low |
| port_irq_n | output | 8 | Port pins carrying the routed request, active low |
| fast_rate | output | 1 | Double-data-rate request |

## Verification
The bench builds the block with its default parameters: a 4-bit address at offset 0x09 and eight port pins. With these values all eight pin-select codes can be reached, and so can every combination of the three enable bits. Addresses next to the register offset can also be reached, which exercises the ignored-write and zero-read paths. Each cycle the bench compares every output against a behavioural model. The model holds its own copy of the register and works out the priority winner with plain conditionals. The tests cover directed priority conflicts, a sweep over all pin selects, and randomised traffic.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    localparam int PIN_COUNT = 8;
    localparam int PIN_SEL_W = $clog2(PIN_COUNT);

    // Stored register fields, bit 0 is the LSB of the register
    typedef struct packed {
        logic                 fast_rate;
        logic [PIN_SEL_W-1:0] pin_sel;
        logic                 en_port;
        logic                 en_int1;
        logic                 en_int0;
    } steer_cfg_t;

    localparam int CFG_W = $bits(steer_cfg_t);

    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_INT0 = 2'd1,
        DEST_INT1 = 2'd2,
        DEST_PORT = 2'd3
    } dest_e;

    // Fixed priority resolution of the enabled destinations
    function automatic dest_e pick_dest(input steer_cfg_t cfg, input logic req);
        dest_e d;
        d = DEST_NONE;
        if (req) begin
            if (cfg.en_int0)      d = DEST_INT0;
            else if (cfg.en_int1) d = DEST_INT1;
            else if (cfg.en_port) d = DEST_PORT;
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_steer_cfg_reg.sv
module irq_steer_cfg_reg
    import irq_steer_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          DATA_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 4'h9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output steer_cfg_t        cfg
);

    localparam int PAD_W = DATA_W - CFG_W;

    logic hit;
    assign hit = (addr == REG_OFFSET);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we && hit) begin
            cfg <= steer_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) rdata = {{PAD_W{1'b0}}, cfg};
    end

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
        (we && hit) |=> (cfg == $past(wdata[CFG_W-1:0]))); // R2
    AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !(we && hit) |=> $stable(cfg)); // R3
    AST_RSVD_READ: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1] == 1'b0); // R2

endmodule

// File: rtl/irq_steer_arbiter.sv
module irq_steer_arbiter
    import irq_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  steer_cfg_t cfg,
    input  logic       req,
    output logic       fire_int0,
    output logic       fire_int1,
    output logic       fire_port
);

    dest_e winner;

    always_comb begin
        winner    = pick_dest(cfg, req);
        fire_int0 = (winner == DEST_INT0);
        fire_int1 = (winner == DEST_INT1);
        fire_port = (winner == DEST_PORT);
    end

    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fire_int0, fire_int1, fire_port})); // R5
    AST_INT0_TOP: assert property (@(posedge clk) disable iff (rst)
        (req && cfg.en_int0) |-> (fire_int0 && !fire_int1 && !fire_port)); // R5
    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req |-> !(fire_int0 || fire_int1 || fire_port)); // R10

endmodule

// File: rtl/irq_steer_pin_decode.sv
module irq_steer_pin_decode #(
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic [SEL_W-1:0]    sel,
    output logic [NUM_PINS-1:0] pin_n
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        assign pin_n[g] = !(fire && (sel == SEL_W'(g)));
    end

    AST_PINS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !fire |-> (&pin_n)); // R8
    AST_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
        fire |-> ($countones(~pin_n) == 1)); // R7

endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 4'h9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 core_irq,
    input  logic                 host_int0_n_in,
    input  logic                 host_int1_n_in,
    output logic                 host_int0_n_out,
    output logic                 host_int1_n_out,
    output logic [PIN_COUNT-1:0] port_irq_n,
    output logic                 fast_rate
);

    steer_cfg_t cfg;
    logic       fire_int0;
    logic       fire_int1;
    logic       fire_port;

    irq_steer_cfg_reg #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_OFFSET(REG_OFFSET)
    ) u_reg (
        .clk  (clk),
        .rst  (rst),
        .addr (bus_addr),
        .we   (bus_we),
        .wdata(bus_wdata),
        .rdata(bus_rdata),
        .cfg  (cfg)
    );

    irq_steer_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .req      (core_irq),
        .fire_int0(fire_int0),
        .fire_int1(fire_int1),
        .fire_port(fire_port)
    );

    irq_steer_pin_decode #(
        .NUM_PINS(PIN_COUNT)
    ) u_dec (
        .clk  (clk),
        .rst  (rst),
        .fire (fire_port),
        .sel  (cfg.pin_sel),
        .pin_n(port_irq_n)
    );

    // Wired-AND merge on the active-low host lines
    assign host_int0_n_out = host_int0_n_in & ~fire_int0;
    assign host_int1_n_out = host_int1_n_in & ~fire_int1;
    assign fast_rate       = cfg.fast_rate;

    AST_MERGE0: assert property (@(posedge clk) disable iff (rst)
        !host_int0_n_in |-> !host_int0_n_out); // R6
    AST_MERGE1: assert property (@(posedge clk) disable iff (rst)
        !host_int1_n_in |-> !host_int1_n_out); // R6
    AST_INT0_ROUTED: assert property (@(posedge clk) disable iff (rst)
        (core_irq && bus_rdata[0] && bus_addr == REG_OFFSET) |-> !host_int0_n_out); // R4
    AST_RATE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        (!core_irq && host_int0_n_in && host_int1_n_in) |->
        (host_int0_n_out && host_int1_n_out && (&port_irq_n))); // R9

endmodule

// File: tb/sim_irq_steer_top.sv
module sim_irq_steer_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] OFF = 4'h9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       core_irq = 1'b0;
    logic       in0_n = 1'b1;
    logic       in1_n = 1'b1;
    logic       out0_n;
    logic       out1_n;
    logic [7:0] port_n;
    logic       fast_rate;

    int checks = 0;
    int fails  = 0;
    logic [6:0] shadow;
    bit done = 0;

    irq_steer_top u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_irq(core_irq),
        .host_int0_n_in(in0_n), .host_int1_n_in(in1_n),
        .host_int0_n_out(out0_n), .host_int1_n_out(out1_n),
        .port_irq_n(port_n), .fast_rate(fast_rate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model of the stored register
    always @(posedge clk) begin
        if (rst) shadow <= 7'h00;
        else if (bus_we && bus_addr == OFF) shadow <= bus_wdata[6:0];
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        bit w0, w1, wp;
        logic [7:0] ep;
        w0 = core_irq && shadow[0];
        w1 = core_irq && !shadow[0] && shadow[1];
        wp = core_irq && !shadow[0] && !shadow[1] && shadow[2];
        ep = 8'hFF;
        if (wp) ep[shadow[5:3]] = 1'b0;
        check(bus_addr == OFF ? "R2 readback" : "R3 miss read",
              bus_rdata, bus_addr == OFF ? {1'b0, shadow} : 8'h00);
        check("R4 R6 int0 merge", {7'b0, out0_n}, {7'b0, in0_n & ~w0});
        check("R5 R6 int1 merge", {7'b0, out1_n}, {7'b0, in1_n & ~w1});
        check("R7 R8 port pins", port_n, ep);
        check("R9 rate bit", {7'b0, fast_rate}, {7'b0, shadow[6]});
    endtask

    // Drive at negedge, compare a quarter period later
    task automatic cyc(input logic [3:0] a, input logic we, input logic [7:0] d,
                       input logic irq, input logic i0, input logic i1);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d;
        core_irq = irq; in0_n = i0; in1_n = i1;
        #(CLK_PERIOD/4);
        if (!rst) compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        #(CLK_PERIOD/4);
        check("R1 reset read", bus_rdata, 8'h00);
        check("R1 reset pins", port_n, 8'hFF);
        check("R1 reset int", {6'b0, out1_n, out0_n}, 8'h03);
        cyc(OFF, 0, 0, 0, 1, 1);
        cyc(OFF, 0, 0, 1, 1, 1);
        // R10: write then see effect next cycle; all enables -> int0 wins (R5)
        cyc(OFF, 1, 8'hFF, 1, 1, 1);
        cyc(OFF, 0, 0, 1, 1, 1);
        check("R2 reserved bit 7", bus_rdata, 8'h7F);
        check("R5 int0 beats others", {6'b0, out1_n, out0_n}, 8'h02);
        check("R5 port quiet", port_n, 8'hFF);
        // int1 over port
        cyc(OFF, 1, 8'h06, 1, 1, 1);
        cyc(OFF, 0, 0, 1, 1, 1);
        check("R5 int1 beats port", {6'b0, out1_n, out0_n}, 8'h01);
        // R6 other sources low while routing elsewhere
        cyc(OFF, 0, 0, 1, 0, 1);
        cyc(OFF, 0, 0, 0, 0, 0);
        // R3 write at other offsets ignored
        cyc(4'h8, 1, 8'h01, 1, 1, 1);
        cyc(4'hA, 1, 8'h01, 1, 1, 1);
        cyc(OFF, 0, 0, 1, 1, 1);
        check("R3 ignored write", bus_rdata, 8'h06);
        // R7 sweep of all pin selects with rate bit toggling (R9)
        for (int s = 0; s < 8; s++) begin
            cyc(OFF, 1, {1'b0, s[0], s[2:0], 3'b100}, 0, 1, 1);
            cyc(OFF, 0, 0, 1, 1, 1);
            check("R7 selected pin", port_n, ~(8'h01 << s));
            cyc(OFF, 0, 0, 0, 1, 1);
            check("R10 request drop", port_n, 8'hFF);
        end
        // Randomised traffic
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            cyc((r[3:0] < 4'd10) ? OFF : r[7:4], r[8] & r[9], r[17:10],
                r[18], r[19] | r[20], r[21] | r[22]);
        end
        // R1 reset again clears the fields
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; bus_addr = OFF; bus_we = 0;
        #(CLK_PERIOD/4);
        check("R1 re-reset read", bus_rdata, 8'h00);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule